// File: doc/BRIEF.md
# Processor Exception and Trap Unit

This unit sits next to the control sequencer of a simple multicycle processor and turns fault and interrupt conditions into a change of control flow. Each cycle it looks at three detection inputs (an undefined-instruction flag, an arithmetic-overflow flag and an external interrupt request), the address of the current instruction and a return-from-exception command. When it takes an exception it records a cause code, saves the current instruction address in a dedicated exception return register, switches to kernel mode with interrupts masked, and on the next cycle presents a replacement program counter with a one-cycle redirect strobe.

The handler address is either one fixed entry point or a per-cause slot of 32 instructions, chosen by a mode-select input. A return command restores the previous privilege mode, turns interrupts back on and redirects to the saved address, all in one step. The status keeps a one-level stack of the privilege mode: entry pushes the current mode, return pops it.

Top module: `trap_unit`

## Requirements
- R1: After reset the unit is in kernel mode with interrupts disabled, the redirect strobe is low, and the cause code, exception return address and next-PC output are all zero; the saved previous mode is user (0).
- R2: An undefined-instruction flag causes, one cycle later, a redirect with cause code 0 and the exception return address equal to the PC presented with the flag.
- R3: An overflow flag without an undefined-instruction flag causes, one cycle later, a redirect with cause code 1 and the exception return address equal to the presented PC.
- R4: An interrupt request is taken (cause code 2, return address equal to the presented PC) only while the interrupt-enable output is 1.
- R5: An interrupt request seen while interrupts are disabled is remembered and is taken in the cycle after interrupts become enabled, even if the request is no longer present.
- R6: When several conditions occur in one cycle the order is: undefined instruction, then overflow, then return command, then interrupt; the lower ones are not acted on in that cycle.
- R7: Taking an exception sets the mode output to kernel (1) and the interrupt-enable output to 0, and saves the prior mode as the previous mode.
- R8: A return command (with no trap present) sets the mode output to the saved previous mode, sets interrupt enable to 1, drives next PC to the saved return address and pulses redirect.
- R9: With the mode-select input at 0 an exception drives next PC to 0x80000080.
- R10: With the mode-select input at 1 an exception drives next PC to 0x80 + (cause code << 7), so 0x80, 0x100 and 0x180 for codes 0, 1 and 2.
- R11: Redirect is high for exactly the one cycle following each exception taken or return executed; the cause code and return address change only when an exception is taken, and next PC holds between redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| undefInsn | input | 1 | Current instruction has an undefined opcode |
| arithOvf | input | 1 | Current instruction overflowed |
| irqReq | input | 1 | External interrupt request |
| eretCmd | input | 1 | Return-from-exception command |
| vectorMode | input | 1 | 0: fixed entry point, 1: per-cause slots |
| curPc | input | 32 | Address of the current instruction |
| redirect | output | 1 | One-cycle strobe: take nextPc |
| nextPc | output | 32 | Program counter override |
| causeCode | output | 4 | Recorded exception cause |
| excPc | output | 32 | Saved exception return address |
| kernelMode | output | 1 | 1 when in kernel mode |
| irqEnable | output | 1 | 1 when interrupts are accepted |

## Verification
Every result lands one clock after the edge that samples its condition: cause, return address, status, next PC and redirect are all registers fed directly from that edge. A remembered interrupt needs one further cycle, since interrupt enable must first become 1 and is only then seen by the acceptance logic, so its redirect arrives two cycles after the return command. The bench drives inputs just after a falling edge and compares at the following falling edge, exactly one rising edge later, and steps one extra falling edge for the deferred interrupt.

// File: rtl/trap_pkg.sv
package trap_pkg;
  parameter int CAUSE_W = 4;

  localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = CAUSE_W'(0);
  localparam logic [CAUSE_W-1:0] CAUSE_OVF   = CAUSE_W'(1);
  localparam logic [CAUSE_W-1:0] CAUSE_IRQ   = CAUSE_W'(2);

  // Strobes from control to datapath
  typedef struct packed {
    logic                take;
    logic                ret;
    logic [CAUSE_W-1:0]  code;
  } trapStb_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     undefInsn,
  input  logic     arithOvf,
  input  logic     irqReq,
  input  logic     eretCmd,
  input  logic     ieIn,
  output trapStb_t stb
);
  logic irqPend;
  logic trapHit;
  logic retHit;
  logic irqHit;

  assign trapHit = undefInsn | arithOvf;
  assign retHit  = eretCmd & ~trapHit;
  assign irqHit  = ieIn & (irqReq | irqPend) & ~trapHit & ~eretCmd;

  always_comb begin
    stb      = '0;
    stb.take = trapHit | irqHit;
    stb.ret  = retHit;
    if (undefInsn)     stb.code = CAUSE_UNDEF;
    else if (arithOvf) stb.code = CAUSE_OVF;
    else if (irqHit)   stb.code = CAUSE_IRQ;
    else               stb.code = CAUSE_UNDEF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqPend <= 1'b0;
    else       irqPend <= (irqPend | irqReq) & ~irqHit;
  end

  assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.take && stb.code == CAUSE_IRQ) |-> ieIn);

  assert_ovf_below_undef_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.take && stb.code == CAUSE_OVF) |-> !undefInsn);

  assert_take_ret_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.take && stb.ret));
endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter logic [31:0] FIXED_ENTRY = 32'h8000_0080,
  parameter logic [31:0] VEC_BASE    = 32'h0000_0080,
  parameter int          VEC_SHIFT   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  trapStb_t           stb,
  input  logic               vectorMode,
  input  logic [XLEN-1:0]    curPc,
  output logic               redirect,
  output logic [XLEN-1:0]    nextPc,
  output logic [CAUSE_W-1:0] causeCode,
  output logic [XLEN-1:0]    excPc,
  output logic               kernelMode,
  output logic               irqEnable
);
  localparam logic [XLEN-1:0] FIXED_X = XLEN'(FIXED_ENTRY);
  localparam logic [XLEN-1:0] BASE_X  = XLEN'(VEC_BASE);

  logic            prevKernel;
  logic [XLEN-1:0] entryPc;

  always_comb begin
    if (vectorMode) entryPc = BASE_X + (XLEN'(stb.code) << VEC_SHIFT);
    else            entryPc = FIXED_X;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirect   <= 1'b0;
      nextPc     <= '0;
      causeCode  <= '0;
      excPc      <= '0;
      kernelMode <= 1'b1;
      irqEnable  <= 1'b0;
      prevKernel <= 1'b0;
    end else if (stb.take) begin
      redirect   <= 1'b1;
      nextPc     <= entryPc;
      causeCode  <= stb.code;
      excPc      <= curPc;
      prevKernel <= kernelMode;
      kernelMode <= 1'b1;
      irqEnable  <= 1'b0;
    end else if (stb.ret) begin
      redirect   <= 1'b1;
      nextPc     <= excPc;
      kernelMode <= prevKernel;
      irqEnable  <= 1'b1;
    end else begin
      redirect   <= 1'b0;
    end
  end

  assert_entry_masks_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |=> (kernelMode && !irqEnable && redirect));

  assert_return_enables_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.ret |=> (irqEnable && redirect && nextPc == $past(excPc)));

  assert_record_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.take |=> ($stable(causeCode) && $stable(excPc)));

  assert_redirect_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.take || stb.ret) |=> !redirect);
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter logic [31:0] FIXED_ENTRY = 32'h8000_0080,
  parameter logic [31:0] VEC_BASE    = 32'h0000_0080,
  parameter int          VEC_SHIFT   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               undefInsn,
  input  logic               arithOvf,
  input  logic               irqReq,
  input  logic               eretCmd,
  input  logic               vectorMode,
  input  logic [XLEN-1:0]    curPc,
  output logic               redirect,
  output logic [XLEN-1:0]    nextPc,
  output logic [CAUSE_W-1:0] causeCode,
  output logic [XLEN-1:0]    excPc,
  output logic               kernelMode,
  output logic               irqEnable
);
  trapStb_t stb;

  trap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .undefInsn(undefInsn), .arithOvf(arithOvf), .irqReq(irqReq),
    .eretCmd(eretCmd), .ieIn(irqEnable), .stb(stb)
  );

  trap_dp #(
    .XLEN(XLEN), .FIXED_ENTRY(FIXED_ENTRY),
    .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .vectorMode(vectorMode),
    .curPc(curPc), .redirect(redirect), .nextPc(nextPc),
    .causeCode(causeCode), .excPc(excPc),
    .kernelMode(kernelMode), .irqEnable(irqEnable)
  );
endmodule

// File: tb/trap_unit_bench.sv
`timescale 1ns/1ps
module trap_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        undefInsn = 1'b0, arithOvf = 1'b0, irqReq = 1'b0, eretCmd = 1'b0;
  logic        vectorMode = 1'b0;
  logic [31:0] curPc = '0;
  logic        redirect;
  logic [31:0] nextPc;
  logic [3:0]  causeCode;
  logic [31:0] excPc;
  logic        kernelMode, irqEnable;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  trap_unit u_trap_unit (
    .clk(clk), .rstN(rstN), .undefInsn(undefInsn), .arithOvf(arithOvf),
    .irqReq(irqReq), .eretCmd(eretCmd), .vectorMode(vectorMode), .curPc(curPc),
    .redirect(redirect), .nextPc(nextPc), .causeCode(causeCode), .excPc(excPc),
    .kernelMode(kernelMode), .irqEnable(irqEnable)
  );

  typedef struct packed {
    logic        undef, ovf, irq, eret, vmode;
    logic [31:0] pc;
    logic        expRedir;
    logic [3:0]  expCause;
    logic [31:0] expNext;
    logic [31:0] expEpc;
    logic        expKern, expIe;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    // R8: return from reset state, previous mode user
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0,   1'b1, 4'd0, 32'h0,         32'h0,   1'b0, 1'b1},
    // R2 R9: undefined, fixed entry
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 32'h100, 1'b1, 4'd0, 32'h8000_0080, 32'h100, 1'b1, 1'b0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0,   1'b1, 4'd0, 32'h100,       32'h100, 1'b0, 1'b1},
    // R3 R10: overflow, vectored
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 32'h204, 1'b1, 4'd1, 32'h100,       32'h204, 1'b1, 1'b0},
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 32'h0,   1'b1, 4'd1, 32'h204,       32'h204, 1'b0, 1'b1},
    // R4 R10: interrupt while enabled, vectored
    '{1'b0,1'b0,1'b1,1'b0,1'b1, 32'h300, 1'b1, 4'd2, 32'h180,       32'h300, 1'b1, 1'b0},
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 32'h0,   1'b1, 4'd2, 32'h300,       32'h300, 1'b0, 1'b1},
    // R6: undefined over overflow
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 32'h400, 1'b1, 4'd0, 32'h80,        32'h400, 1'b1, 1'b0},
    // R6 R7: overflow over return, kernel pushed as previous
    '{1'b0,1'b1,1'b0,1'b1,1'b1, 32'h500, 1'b1, 4'd1, 32'h100,       32'h500, 1'b1, 1'b0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0,   1'b1, 4'd1, 32'h500,       32'h500, 1'b1, 1'b1},
    // R11: idle, everything holds
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,   1'b0, 4'd1, 32'h500,       32'h500, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic u, input logic o, input logic i, input logic e,
                       input logic v, input logic [31:0] pc);
    undefInsn = u; arithOvf = o; irqReq = i; eretCmd = e; vectorMode = v; curPc = pc;
  endtask

  task automatic chkAll(input string req, input logic r, input logic [3:0] c,
                        input logic [31:0] n, input logic [31:0] ep,
                        input logic k, input logic ie);
    chk(req, "redirect", 32'(redirect), 32'(r));
    chk(req, "causeCode", 32'(causeCode), 32'(c));
    chk(req, "nextPc", nextPc, n);
    chk(req, "excPc", excPc, ep);
    chk(req, "kernelMode", 32'(kernelMode), 32'(k));
    chk(req, "irqEnable", 32'(irqEnable), 32'(ie));
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chkAll("R1", 1'b0, 4'd0, 32'h0, 32'h0, 1'b1, 1'b0);

    for (int k = 0; k < NVEC; k++) begin
      drive(VECS[k].undef, VECS[k].ovf, VECS[k].irq, VECS[k].eret, VECS[k].vmode, VECS[k].pc);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
      chkAll($sformatf("R2/R3 vec%0d", k), VECS[k].expRedir, VECS[k].expCause,
             VECS[k].expNext, VECS[k].expEpc, VECS[k].expKern, VECS[k].expIe);
    end

    // R5: interrupt arriving while masked waits for enable
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h600);
    @(negedge clk);
    chkAll("R2", 1'b1, 4'd0, 32'h8000_0080, 32'h600, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h700);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h800);
    chkAll("R5 masked", 1'b0, 4'd0, 32'h8000_0080, 32'h600, 1'b1, 1'b0);
    @(negedge clk);
    chk("R5 still waiting", "redirect", 32'(redirect), 32'h0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h800);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h800);
    chkAll("R8", 1'b1, 4'd0, 32'h600, 32'h600, 1'b1, 1'b1);
    @(negedge clk);
    chkAll("R5 deferred", 1'b1, 4'd2, 32'h8000_0080, 32'h800, 1'b1, 1'b0);
    @(negedge clk);
    chk("R11 pulse", "redirect", 32'(redirect), 32'h0);

    // R6: return beats interrupt; interrupt then taken from memory
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h900);
    @(negedge clk);
    chk("R8", "irqEnable", 32'(irqEnable), 32'h1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h900);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h900);
    chkAll("R6 eret over irq", 1'b1, 4'd2, 32'h800, 32'h800, 1'b1, 1'b1);
    @(negedge clk);
    chkAll("R10 irq slot", 1'b1, 4'd2, 32'h180, 32'h900, 1'b1, 1'b0);
    @(negedge clk);
    chk("R11 pulse", "redirect", 32'(redirect), 32'h0);

    // R1: reset again mid-run
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chkAll("R1 rerun", 1'b0, 4'd0, 32'h0, 32'h0, 1'b1, 1'b0);

    finished = 1'b1;
    summary();
  end
endmodule